// File: doc/BRIEF.md
# Read-Modify-Write Shift Unit

This block runs the bus sequence for a one-bit left shift of a byte operand, taken either from memory or from the accumulator, and updates the carry, negative and zero flags. It is started once the address of the operand has been settled elsewhere. It then drives the read strobe, the write strobe with its data, the accumulator write-back and the flag write-back, cycle by cycle, until it signals that the next opcode may be fetched.

A memory operand is read. The byte is then written back unchanged, and the shifted byte is written back after it. This double write is the expected bus behaviour, and devices that react to writes depend on it. When the opcode's low nibble selects the accumulator, the unit spends one dummy fetch cycle, writes the shifted value back to the accumulator in that cycle, and makes no memory writes. The indexed absolute form always makes two reads before it writes and has no shortcut. Address generation is not part of the block.

Top module: `rmw_shift_unit`

## Requirements
- R1: A start pulse is accepted only in idle and only when opcode bits [1:0] are 2'b10 and bits [7:5] are 3'b000. Any other opcode leaves the unit idle, with every strobe low.
- R2: When opcode bits [3:0] equal 4'hA, the sequence is one cycle with rd_en, acc_we and flags_we high, where acc_out is the shifted acc_in, followed by one fetch cycle. wr_en stays low throughout.
- R3: The result is the operand shifted left by one with 0 entering bit 0. Flag bit 0 (carry) takes the operand's old bit 7.
- R4: Flag bit 7 (negative) equals bit 7 of the result. Flag bit 1 (zero) is 1 exactly when the result is 0.
- R5: For other memory forms, the four cycles after the accepting edge are: read (rd_en), write of the original byte, write of the shifted byte with flags_we, and fetch. The unit is then idle.
- R6: When opcode bits [4:2] are 3'b111 (indexed absolute, memory mode), two read cycles come before the writes. The byte from the second read is the operand.
- R7: Flag bits 2 to 6 pass from flags_in to flags_out unchanged. With flags_we low, flags_out equals flags_in.
- R8: A start arriving while busy is ignored, and the running sequence carries on unchanged.
- R9: After synchronous reset, busy, rd_en, wr_en, acc_we, flags_we and fetch are low, and wr_data and acc_out are 0 whenever their strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence for `opcode` |
| opcode | input | 8 | Instruction byte, sampled with start |
| data_in | input | 8 | Bus read data |
| rd_en | output | 1 | Bus read (or dummy fetch) cycle |
| wr_en | output | 1 | Bus write strobe |
| wr_data | output | 8 | Bus write data, 0 when not writing |
| acc_in | input | 8 | Current accumulator |
| acc_we | output | 1 | Accumulator write-back strobe |
| acc_out | output | 8 | Shifted accumulator, 0 when not writing |
| flags_in | input | 8 | Current flag register |
| flags_we | output | 1 | Flag register write strobe |
| flags_out | output | 8 | Updated flag register |
| busy | output | 1 | Sequence in progress |
| fetch | output | 1 | Next-opcode fetch cycle |

## Verification
The bench targets the operands 0x80 and 0x00, where the result is zero. It also targets 0xFF and 0x40, where the result sets the negative flag. A design that takes carry or zero from the wrong side of the shift shows a wrong flags_out on exactly those cycles. For the indexed absolute form, data_in carries junk on the first read, so a design that captures the operand on that read writes back the junk value. Opcodes that share the accumulator nibble with a different upper field (0x1A against 0x2A), and a start held high through a sequence, expose decoders that ignore bits [7:5] and a controller that restarts mid-sequence. Flag inputs of all ones and all zeros show whether any untouched flag bit gets overwritten.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    localparam int OP_W   = 8;
    localparam int DATA_W = 8;
    localparam int FLAG_W = 8;

    // flag bit positions in the status register
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DUMMY,
        ST_RD,
        ST_WR_OLD,
        ST_WR_NEW,
        ST_ACC,
        ST_FETCH
    } rmw_state_e;

    typedef enum logic [1:0] {
        MODE_ACC,
        MODE_MEM,
        MODE_MEM_IDX
    } rmw_mode_e;

    typedef struct packed {
        logic carry;
        logic neg;
        logic zero;
    } cnz_t;

    function automatic logic is_shift_grp(input logic [OP_W-1:0] op);
        return (op[1:0] == 2'b10) && (op[7:5] == 3'b000);
    endfunction

    function automatic rmw_mode_e classify(input logic [OP_W-1:0] op);
        if (op[3:0] == 4'hA)
            return MODE_ACC;
        else if (op[4:2] == 3'b111)
            return MODE_MEM_IDX;
        else
            return MODE_MEM;
    endfunction

endpackage

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
    import rmw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] opcode,
    output logic            busy,
    output logic            rd_en,
    output logic            cap_en,
    output logic            wr_en,
    output logic            sel_new,
    output logic            acc_we,
    output logic            flags_we,
    output logic            fetch
);

    rmw_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && is_shift_grp(opcode)) begin
                    unique case (classify(opcode))
                        MODE_ACC:     state_d = ST_ACC;
                        MODE_MEM_IDX: state_d = ST_RD_DUMMY;
                        default:      state_d = ST_RD;
                    endcase
                end
            end
            ST_RD_DUMMY: state_d = ST_RD;
            ST_RD:       state_d = ST_WR_OLD;
            ST_WR_OLD:   state_d = ST_WR_NEW;
            ST_WR_NEW:   state_d = ST_FETCH;
            ST_ACC:      state_d = ST_FETCH;
            ST_FETCH:    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign busy     = (state_q != ST_IDLE);
    assign rd_en    = (state_q == ST_RD_DUMMY) || (state_q == ST_RD) || (state_q == ST_ACC);
    assign cap_en   = (state_q == ST_RD);
    assign wr_en    = (state_q == ST_WR_OLD) || (state_q == ST_WR_NEW);
    assign sel_new  = (state_q == ST_WR_NEW);
    assign acc_we   = (state_q == ST_ACC);
    assign flags_we = (state_q == ST_WR_NEW) || (state_q == ST_ACC);
    assign fetch    = (state_q == ST_FETCH);

    AST_WR_PAIR: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WR_OLD) |=> (state_q == ST_WR_NEW)); // R5
    AST_FETCH_ENDS: assert property (@(posedge clk) disable iff (rst)
        fetch |=> !busy); // R5
    AST_IDX_TWO_READS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RD_DUMMY) |=> (state_q == ST_RD)); // R6
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !fetch) |=> busy); // R8
    AST_IDLE_REJECT: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(start && is_shift_grp(opcode))) |=> !busy); // R1

endmodule

// File: rtl/rmw_shift.sv
module rmw_shift
    import rmw_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_en,
    input  logic          use_acc,
    input  logic [DW-1:0] data_in,
    input  logic [DW-1:0] acc_in,
    output logic [DW-1:0] operand,
    output logic [DW-1:0] result,
    output cnz_t          cnz
);

    logic [DW-1:0] opnd_q;
    logic [DW-1:0] src;

    always_ff @(posedge clk) begin
        if (rst)         opnd_q <= '0;
        else if (cap_en) opnd_q <= data_in;
    end

    assign src       = use_acc ? acc_in : opnd_q;
    assign result    = {src[DW-2:0], 1'b0};
    assign cnz.carry = src[DW-1];
    assign cnz.neg   = result[DW-1];
    assign cnz.zero  = (result == '0);
    assign operand   = opnd_q;

endmodule

// File: rtl/rmw_flags.sv
module rmw_flags
    import rmw_pkg::*;
#(
    parameter int FW = FLAG_W
) (
    input  logic [FW-1:0] flags_in,
    input  cnz_t          cnz,
    input  logic          we,
    output logic [FW-1:0] flags_out
);

    for (genvar i = 0; i < FW; i++) begin : g_bit
        if (i == FLG_C) begin : g_c
            assign flags_out[i] = we ? cnz.carry : flags_in[i];
        end else if (i == FLG_Z) begin : g_z
            assign flags_out[i] = we ? cnz.zero : flags_in[i];
        end else if (i == FLG_N) begin : g_n
            assign flags_out[i] = we ? cnz.neg : flags_in[i];
        end else begin : g_keep
            assign flags_out[i] = flags_in[i];
        end
    end

    always_comb begin
        AST_KEEP_OTHERS: assert ((flags_out[6:2] == flags_in[6:2]) || $isunknown(flags_in)); // R7
    end

endmodule

// File: rtl/rmw_shift_unit.sv
module rmw_shift_unit
    import rmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] data_in,
    output logic              rd_en,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] acc_in,
    output logic              acc_we,
    output logic [DATA_W-1:0] acc_out,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              flags_we,
    output logic [FLAG_W-1:0] flags_out,
    output logic              busy,
    output logic              fetch
);

    logic              cap_en, sel_new;
    logic [DATA_W-1:0] operand, result;
    cnz_t              cnz;

    rmw_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .opcode   (opcode),
        .busy     (busy),
        .rd_en    (rd_en),
        .cap_en   (cap_en),
        .wr_en    (wr_en),
        .sel_new  (sel_new),
        .acc_we   (acc_we),
        .flags_we (flags_we),
        .fetch    (fetch)
    );

    rmw_shift #(.DW(DATA_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .use_acc (acc_we),
        .data_in (data_in),
        .acc_in  (acc_in),
        .operand (operand),
        .result  (result),
        .cnz     (cnz)
    );

    rmw_flags #(.FW(FLAG_W)) u_flags (
        .flags_in  (flags_in),
        .cnz       (cnz),
        .we        (flags_we),
        .flags_out (flags_out)
    );

    assign wr_data = !wr_en ? '0 : (sel_new ? result : operand);
    assign acc_out = acc_we ? result : '0;

    AST_ACC_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        acc_we |-> !wr_en); // R2
    AST_CARRY_OLD_BIT: assert property (@(posedge clk) disable iff (rst)
        (flags_we && wr_en) |-> (flags_out[FLG_C] == $past(wr_data[DATA_W-1]))); // R3
    AST_SHIFT_VALUE: assert property (@(posedge clk) disable iff (rst)
        (flags_we && wr_en) |-> (wr_data == {$past(wr_data[DATA_W-2:0]), 1'b0})); // R3
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        flags_we |-> (flags_out[FLG_Z] == ((acc_we ? acc_out : wr_data) == '0))); // R4
    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
        flags_we |-> (flags_out[FLG_N] == (acc_we ? acc_out[DATA_W-1] : wr_data[DATA_W-1]))); // R4

endmodule

// File: tb/test_rmw_shift_unit.sv
module test_rmw_shift_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [7:0] data_in = 8'h00;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] flags_in = 8'h00;
    logic       rd_en, wr_en, acc_we, flags_we, busy, fetch;
    logic [7:0] wr_data, acc_out, flags_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rmw_shift_unit i_rmw_shift_unit (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .data_in(data_in),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .acc_in(acc_in),
        .acc_we(acc_we), .acc_out(acc_out), .flags_in(flags_in),
        .flags_we(flags_we), .flags_out(flags_out), .busy(busy), .fetch(fetch)
    );

    typedef struct {
        logic [7:0] din;
        logic       rd, wr, awe, fwe, fe, bz;
        logic [7:0] wd, ad, fd;
        string      tag;
    } exp_t;

    exp_t q[$];

    function automatic exp_t idle_cycle(input logic [7:0] pin, input string tag);
        exp_t e;
        e.din = 8'h00; e.rd = 0; e.wr = 0; e.awe = 0; e.fwe = 0; e.fe = 0; e.bz = 0;
        e.wd = 8'h00; e.ad = 8'h00; e.fd = pin; e.tag = tag;
        return e;
    endfunction

    task automatic compare(input exp_t e);
        logic [36:0] act, expv;
        act  = {rd_en, wr_en, wr_data, acc_we, acc_out, flags_we, flags_out, fetch, busy};
        expv = {e.rd, e.wr, e.wd, e.awe, e.ad, e.fwe, e.fd, e.fe, e.bz};
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (rd wr wd awe ad fwe fd fe bz)", e.tag, act, expv);
        end
    endtask

    // behavioural reference: builds the expected per-cycle trace for one operation
    task automatic run_op(input logic [7:0] op, input logic [7:0] opnd, input logic [7:0] junk,
                          input logic [7:0] acc, input logic [7:0] pin, input bit hammer,
                          input string tag);
        bit         grp, accm, idx;
        logic [7:0] src, res, fl;
        exp_t       e;
        grp  = (op[1:0] == 2'b10) && (op[7:5] == 3'b000);
        accm = (op[3:0] == 4'hA);
        idx  = (op[4:2] == 3'b111);
        src  = accm ? acc : opnd;
        res  = {src[6:0], 1'b0};
        fl   = pin;
        fl[0] = src[7];
        fl[1] = (res == 8'h00);
        fl[7] = res[7];
        q.delete();
        if (grp && accm) begin
            e = idle_cycle(pin, {tag, " R2 acc"}); e.bz = 1; e.rd = 1; e.awe = 1; e.ad = res;
            e.fwe = 1; e.fd = fl; q.push_back(e);
            e = idle_cycle(pin, {tag, " R2 fetch"}); e.bz = 1; e.fe = 1; q.push_back(e);
        end else if (grp) begin
            if (idx) begin
                e = idle_cycle(pin, {tag, " R6 first read"}); e.bz = 1; e.rd = 1; e.din = junk;
                q.push_back(e);
            end
            e = idle_cycle(pin, {tag, " R5 read"}); e.bz = 1; e.rd = 1; e.din = opnd; q.push_back(e);
            e = idle_cycle(pin, {tag, " R5 write old"}); e.bz = 1; e.wr = 1; e.wd = opnd; q.push_back(e);
            e = idle_cycle(pin, {tag, " R3 R4 write new"}); e.bz = 1; e.wr = 1; e.wd = res;
            e.fwe = 1; e.fd = fl; q.push_back(e);
            e = idle_cycle(pin, {tag, " R5 fetch"}); e.bz = 1; e.fe = 1; q.push_back(e);
        end
        q.push_back(idle_cycle(pin, {tag, " R1 idle"}));

        @(negedge clk);
        opcode = op; start = 1'b1; acc_in = acc; flags_in = pin; data_in = 8'hEE;
        for (int i = 0; i < q.size(); i++) begin
            @(negedge clk);
            data_in = q[i].din;
            if (hammer && !q[i].fe && q[i].bz) begin
                start = 1'b1; opcode = 8'h0A; // R8: attempt restart while busy
            end else begin
                start = 1'b0;
            end
            #1;
            compare(q[i]);
        end
    endtask

    initial begin
        exp_t e;
        repeat (3) @(negedge clk);
        #1;
        e = idle_cycle(8'h00, "R9 reset");
        compare(e);
        rst = 1'b0;

        run_op(8'h06, 8'h81, 8'h00, 8'h00, 8'h00, 0, "zpg 81");
        run_op(8'h0E, 8'h40, 8'h00, 8'h00, 8'hFF, 0, "abs 40 R7");
        run_op(8'h16, 8'h80, 8'h00, 8'h00, 8'h7C, 0, "zpgx 80 zero");
        run_op(8'h1E, 8'h00, 8'hFF, 8'h00, 8'h01, 0, "absx 00 R6");
        run_op(8'h1E, 8'hFF, 8'h13, 8'h00, 8'h82, 0, "absx FF R6");
        run_op(8'h0A, 8'h00, 8'h00, 8'hC3, 8'h00, 0, "acc C3");
        run_op(8'h0A, 8'h00, 8'h00, 8'h80, 8'hFF, 0, "acc 80 R4");
        run_op(8'h1A, 8'h00, 8'h00, 8'h01, 8'h80, 0, "acc1A 01");
        run_op(8'h2A, 8'h55, 8'h00, 8'h55, 8'hA5, 0, "rej 2A R1");
        run_op(8'h05, 8'h55, 8'h00, 8'h55, 8'h00, 0, "rej 05 R1");
        run_op(8'hE6, 8'h55, 8'h00, 8'h55, 8'h00, 0, "rej E6 R1");
        run_op(8'h06, 8'h55, 8'h00, 8'h00, 8'h3C, 1, "busy R8");
        run_op(8'h1E, 8'h7F, 8'hAA, 8'h00, 8'h00, 1, "busy absx R8");

        // R9: reset in mid-sequence returns to idle
        @(negedge clk);
        opcode = 8'h0E; start = 1'b1; flags_in = 8'h00;
        @(negedge clk);
        start = 1'b0; rst = 1'b1;
        @(negedge clk);
        #1;
        compare(idle_cycle(8'h00, "R9 reset mid-op"));
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule